// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block is a clocked model of a sequencing handshake component. A single passive port is activated by an upstream partner, and in answer the block drives two active ports in turn. The first downstream partner receives one complete four-phase, return-to-zero handshake. The second downstream partner is then asked, and its acknowledge is what releases the upstream acknowledge. The return-to-zero half of the second handshake is folded into the upstream release. After the upstream request falls, the block lowers the second request, waits for that acknowledge to drop, and only then drops the upstream acknowledge.

All request and acknowledge wires are single-bit levels sampled on the system clock. A parameterised register stage samples every input before the control logic sees it. The control state machine needs one more state than a plain chain of handshakes would. With the upstream request high, it has to tell "not yet started" apart from "finished, waiting for release". All outputs come straight from flip-flops, so each wire makes clean level transitions.

Top module: `hs_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `up_ack`, `first_req` and `second_req` low and returns the block to idle, even in the middle of a handshake.
- R2: When `up_req` rises while the block is idle, `first_req` rises exactly IN_STAGES+1 clock edges after the change, while `second_req` and `up_ack` stay low.
- R3: `first_req` stays high while `first_ack` is low. It falls IN_STAGES+1 edges after `first_ack` rises.
- R4: `second_req` stays low while `first_ack` is still high after `first_req` has fallen. It rises IN_STAGES+1 edges after `first_ack` falls.
- R5: `up_ack` stays low while `second_ack` is low. It rises IN_STAGES+1 edges after `second_ack` rises, and `second_req` is still high at that point.
- R6: `second_req` stays high while `up_req` stays high after `up_ack` has risen. It falls IN_STAGES+1 edges after `up_req` falls, and `up_ack` stays high until `second_ack` is low.
- R7: `up_ack` falls IN_STAGES+1 edges after `second_ack` falls, and the block is then idle. A new `up_req` raised at once starts a new sequence with R2 timing.
- R8: While the block is idle and `up_req` is low, all three outputs stay low, even if either downstream acknowledge toggles.
- R9: At most one output changes per clock edge. Output values, written as {first_req, second_req, up_ack}, cycle only through 000, 100, 000, 010, 011, 001 and back to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Request from the upstream (active) partner |
| up_ack | output | 1 | Acknowledge to the upstream partner |
| first_req | output | 1 | Request to the first downstream partner |
| first_ack | input | 1 | Acknowledge from the first downstream partner |
| second_req | output | 1 | Request to the second downstream partner |
| second_ack | input | 1 | Acknowledge from the second downstream partner |

## Verification
A table of transactions varies how long each downstream partner waits before it acknowledges and how long the upstream partner holds its request. This distinguishes a design that waits on each acknowledge level from one that steps on a fixed schedule. Zero delays expose skipped or merged phases, and long holds expose early transitions. Back-to-back transactions with no idle gap check that the release state goes back to idle cleanly. Directed tests add stray acknowledges while idle and a reset in the middle of a handshake. An event-order monitor watches every output edge against the required cycle.

// File: rtl/seqhs_pkg.sv
`timescale 1ns/1ps
package seqhs_pkg;

  // Phases of one activation. ST_DONE is the auxiliary phase: the upstream
  // request is high but the work is finished and only the release is pending.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_B_REQ  = 3'd1,
    ST_B_RTZ  = 3'd2,
    ST_C_REQ  = 3'd3,
    ST_DONE   = 3'd4,
    ST_C_RTZ  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic first_req;
    logic second_req;
    logic up_ack;
  } seq_out_t;

  function automatic seq_out_t drive_of(seq_state_e s);
    seq_out_t o;
    o = '0;
    case (s)
      ST_B_REQ: o.first_req  = 1'b1;
      ST_C_REQ: o.second_req = 1'b1;
      ST_DONE: begin
        o.second_req = 1'b1;
        o.up_ack     = 1'b1;
      end
      ST_C_RTZ: o.up_ack     = 1'b1;
      default:  o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/seqhs_sampler.sv
`timescale 1ns/1ps
module seqhs_sampler #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_direct
      assign q = d;
    end else begin : g_pipe
      logic [WIDTH-1:0] pipe [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/seqhs_ctrl.sv
`timescale 1ns/1ps
module seqhs_ctrl
  import seqhs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     up_req_s,
  input  logic     first_ack_s,
  input  logic     second_ack_s,
  output seq_out_t drv
);

  seq_state_e state_q, state_d;
  seq_out_t   out_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (up_req_s)      state_d = ST_B_REQ;
      ST_B_REQ: if (first_ack_s)   state_d = ST_B_RTZ;
      ST_B_RTZ: if (!first_ack_s)  state_d = ST_C_REQ;
      ST_C_REQ: if (second_ack_s)  state_d = ST_DONE;
      ST_DONE:  if (!up_req_s)     state_d = ST_C_RTZ;
      ST_C_RTZ: if (!second_ack_s) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      out_q   <= drive_of(state_d);
    end
  end

  assign drv = out_q;

  // R2: a new first request only follows a sampled upstream request
  a_r2_first_after_up: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q.first_req) |-> ($past(up_req_s) && !out_q.second_req && !out_q.up_ack));

  // R3: first request held until its acknowledge is seen
  a_r3_first_held: assert property (@(posedge clk) disable iff (rst)
    (out_q.first_req && !first_ack_s) |=> out_q.first_req);

  // R4: second request only after the first handshake returned to zero
  a_r4_second_after_rtz: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q.second_req) |-> ($past(!first_ack_s) && !out_q.first_req));

  // R5: upstream acknowledge only once the second acknowledge is high
  a_r5_ack_after_second: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q.up_ack) |-> ($past(second_ack_s) && out_q.second_req));

  // R6: upstream acknowledge kept while the second acknowledge is high
  a_r6_ack_kept: assert property (@(posedge clk) disable iff (rst)
    (out_q.up_ack && second_ack_s) |=> out_q.up_ack);

  // R7: upstream acknowledge drops only after second acknowledge is low
  a_r7_ack_release: assert property (@(posedge clk) disable iff (rst)
    $fell(out_q.up_ack) |-> ($past(!second_ack_s) && !out_q.second_req));

  // R8: quiet while idle with no request
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !up_req_s) |=> (out_q == '0));

  // R9: one output edge per clock at most
  a_r9_single_edge: assert property (@(posedge clk) disable iff (rst)
    $countones(out_q ^ $past(out_q)) <= 1);

endmodule

// File: rtl/hs_sequencer.sv
`timescale 1ns/1ps
module hs_sequencer
  import seqhs_pkg::*;
#(
  parameter int IN_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  output logic up_ack,
  output logic first_req,
  input  logic first_ack,
  output logic second_req,
  input  logic second_ack
);

  localparam int N_IN = 3;

  logic [N_IN-1:0] raw_in, smp_in;
  seq_out_t        drv;

  assign raw_in = {up_req, first_ack, second_ack};

  seqhs_sampler #(.WIDTH(N_IN), .STAGES(IN_STAGES)) u_sampler (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (smp_in)
  );

  seqhs_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .up_req_s     (smp_in[2]),
    .first_ack_s  (smp_in[1]),
    .second_ack_s (smp_in[0]),
    .drv          (drv)
  );

  assign first_req  = drv.first_req;
  assign second_req = drv.second_req;
  assign up_ack     = drv.up_ack;

endmodule

// File: tb/hs_sequencer_test.sv
`timescale 1ns/1ps
module hs_sequencer_test;

  localparam int IN_STAGES = 1;
  localparam int LAT = IN_STAGES + 1;
  localparam int NVEC = 8;
  // {first delay, second delay, upstream release delay, idle gap}
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0, 0}, '{1, 0, 2, 1}, '{3, 5, 0, 0}, '{0, 7, 1, 3},
    '{6, 1, 4, 0}, '{2, 2, 2, 2}, '{9, 0, 0, 0}, '{0, 3, 8, 1}
  };
  localparam logic [2:0] SEQ [6] = '{3'b000, 3'b100, 3'b000, 3'b010, 3'b011, 3'b001};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0, first_ack = 1'b0, second_ack = 1'b0;
  logic up_ack, first_req, second_req;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hs_sequencer #(.IN_STAGES(IN_STAGES)) uut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack),
    .first_req(first_req), .first_ack(first_ack),
    .second_req(second_req), .second_ack(second_ack)
  );

  function automatic logic [2:0] outs();
    return {first_req, second_req, up_ack};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_bit(input int w, input logic v, output int cnt);
    logic [2:0] o;
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      o = outs();
      if (o[w] == v || cnt >= 300) break;
    end
  endtask

  task automatic hold(input int n, input logic [2:0] exp, input string req);
    bit ok = 1'b1;
    logic [2:0] seen = exp;
    repeat (n) begin
      @(negedge clk);
      if (outs() !== exp) begin ok = 1'b0; seen = outs(); end
    end
    chk(ok, req, "outputs held", int'(seen), int'(exp));
  endtask

  task automatic txn(input int bd, input int cd, input int rd);
    int n;
    up_req = 1'b1;
    wait_bit(2, 1'b1, n);
    chk(n == LAT, "R2", "first_req rise latency", n, LAT);
    chk(outs() == 3'b100, "R2", "outputs at first_req rise", int'(outs()), 4);
    hold(bd, 3'b100, "R3");
    first_ack = 1'b1;
    wait_bit(2, 1'b0, n);
    chk(n == LAT, "R3", "first_req fall latency", n, LAT);
    hold(bd, 3'b000, "R4");
    first_ack = 1'b0;
    wait_bit(1, 1'b1, n);
    chk(n == LAT, "R4", "second_req rise latency", n, LAT);
    hold(cd, 3'b010, "R5");
    second_ack = 1'b1;
    wait_bit(0, 1'b1, n);
    chk(n == LAT, "R5", "up_ack rise latency", n, LAT);
    chk(outs() == 3'b011, "R5", "second_req high with up_ack", int'(outs()), 3);
    hold(rd, 3'b011, "R6");
    up_req = 1'b0;
    wait_bit(1, 1'b0, n);
    chk(n == LAT, "R6", "second_req fall latency", n, LAT);
    hold(cd, 3'b001, "R6");
    second_ack = 1'b0;
    wait_bit(0, 1'b0, n);
    chk(n == LAT, "R7", "up_ack fall latency", n, LAT);
    chk(outs() == 3'b000, "R7", "outputs idle after release", int'(outs()), 0);
  endtask

  // R9: event-order monitor on every output edge
  logic [2:0] prev_o = 3'b000;
  int seq_idx = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_o = outs();
      seq_idx = 0;
    end else if (outs() !== prev_o) begin
      tests++;
      if (outs() !== SEQ[(seq_idx + 1) % 6]) begin
        fails++;
        $display("FAIL R9 output order: actual %0d expected %0d",
                 outs(), SEQ[(seq_idx + 1) % 6]);
      end
      seq_idx = (seq_idx + 1) % 6;
      prev_o = outs();
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(outs() == 3'b000, "R1", "outputs after reset", int'(outs()), 0);

    // R8: idle, no request, stray acknowledges
    hold(4, 3'b000, "R8");
    first_ack = 1'b1;
    second_ack = 1'b1;
    hold(6, 3'b000, "R8");
    first_ack = 1'b0;
    hold(3, 3'b000, "R8");
    second_ack = 1'b0;
    hold(4, 3'b000, "R8");

    for (int v = 0; v < NVEC; v++) begin
      txn(VEC[v][0], VEC[v][1], VEC[v][2]);
      hold(VEC[v][3], 3'b000, "R7");
    end

    // R1: reset in the middle of the second handshake
    up_req = 1'b1;
    wait_bit(2, 1'b1, n);
    first_ack = 1'b1;
    wait_bit(2, 1'b0, n);
    first_ack = 1'b0;
    wait_bit(1, 1'b1, n);
    chk(outs() == 3'b010, "R1", "second_req up before reset", int'(outs()), 2);
    @(posedge clk);
    #1 rst = 1'b1;
    up_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(outs() == 3'b000, "R1", "outputs after mid reset", int'(outs()), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    hold(3, 3'b000, "R1");

    // R7: recovery and two back-to-back sequences
    txn(1, 1, 1);
    txn(0, 0, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule